// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a memory burst. On a start pulse it captures a starting column, a length code and an ordering bit. From the next clock it presents one column address per cycle, with a valid flag, until the programmed number of beats has been issued. A terminate input can end the burst early.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the starting column. Within that block the beats follow either a sequential order or an interleaved order. The full-page mode walks all the columns of a page in rising order, wraps from the top column to column 0, and keeps running until it is terminated. The block has no part in command decoding, DRAM timing or data movement. It only supplies the column sequence that a controller issues alongside its read or write beats.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, with no start pulse, `colValid` and `lastBeat` are both 0.
- R2: When `start` is 1 at a rising edge while no burst is active, `colValid` is 1 from the next cycle on, and the first beat's `colAddr` equals the captured `startCol`.
- R3: When `interleave`=0 and the burst has 2, 4 or 8 beats, beat k has upper bits (above log2 of the length) equal to those of `startCol`. Its low bits are (`startCol` + k) mod length.
- R4: When `interleave`=1 and the burst has 2, 4 or 8 beats, beat k has upper bits equal to those of `startCol`. Its low bits are the low bits of `startCol` XOR k.
- R5: `lenCode` sets the burst length as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The unused codes 3'b100, 3'b101 and 3'b110 give 1 beat. A fixed burst of N beats shows `colValid`=1 for exactly N consecutive cycles, with one new address per cycle.
- R6: Full-page mode (`lenCode`=3'b111) counts upward by one column per cycle whatever the value of `interleave`. It wraps from column 2^COL_W-1 to column 0 and stays active until it is terminated.
- R7: `lastBeat` is 1 exactly in the cycle of a fixed burst's final beat, and `colValid` is 0 in the following cycle. `lastBeat` is never 1 in full-page mode.
- R8: When `terminate` is 1 at a rising edge during an active burst, the beat shown before that edge is the last one, and `colValid` is 0 in the next cycle. When `terminate` is 1 while idle, it has no effect, including in the cycle a start is accepted.
- R9: A `start` pulse while `colValid` is 1 is ignored: the running burst's address sequence and length are unchanged, and no new burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a burst (accepted only while idle) |
| startCol | input | COL_W | Starting column of the burst |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | Ordering bit: 0 sequential, 1 interleaved |
| terminate | input | 1 | End the active burst after the current beat |
| colAddr | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A beat is being presented |
| lastBeat | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The bench builds the block with the default 8-bit column, so a page has 256 columns. At this width every starting column can be swept for every length code and both orderings. That sweep covers every alignment and wrap position inside the 2-, 4- and 8-beat blocks, and the reserved codes as well. The same width lets a full-page run of 300 beats cross the 255-to-0 wrap in a short run. Early termination, terminate while idle, and starts issued during a burst are each placed at chosen beats.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } strobe_t;

  typedef struct packed {
    logic [3:0] beats;
    logic       full;
  } len_info_t;

  function automatic len_info_t lenDecode(input logic [2:0] code);
    len_info_t info;
    info.full = 1'b0;
    case (code)
      3'b001:  info.beats = 4'd2;
      3'b010:  info.beats = 4'd4;
      3'b011:  info.beats = 4'd8;
      3'b111:  begin info.beats = 4'd0; info.full = 1'b1; end
      default: info.beats = 4'd1;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] lenCode,
  input  logic       terminate,
  output strobe_t    strobes,
  output logic       busy,
  output logic       lastBeat
);

  len_info_t  info;
  logic       active;
  logic       fullMode;
  logic [3:0] remain;
  logic       finalBeat;

  assign info      = lenDecode(lenCode);
  assign finalBeat = active && !fullMode && (remain == 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      fullMode <= 1'b0;
      remain   <= '0;
    end else if (!active) begin
      if (start) begin
        active   <= 1'b1;
        remain   <= info.beats;
        fullMode <= info.full;
      end
    end else if (terminate || finalBeat) begin
      active <= 1'b0;
    end else if (!fullMode) begin
      remain <= remain - 4'd1;
    end
  end

  always_comb begin
    strobes.load = !active && start;
    strobes.step = active && !terminate && !finalBeat;
  end

  assign busy     = active;
  assign lastBeat = finalBeat;

  // R7: final beat closes the burst on the next cycle
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |=> !busy);

  // R7: never a last beat in full-page mode
  a_r7_no_last_full: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fullMode) |-> !lastBeat);

  // R8: terminate during a burst stops it
  a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && terminate) |=> !busy);

  // R2: accepted start gives a valid beat next cycle
  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R9: a start during a burst neither ends nor restarts it
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !terminate && !lastBeat && !fullMode)
      |=> (busy && remain == $past(remain) - 4'd1));

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobes,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colAddr
);

  len_info_t        info;
  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] lowMask;
  logic             ilvMode;
  logic             fullMode;
  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] ilvLow;

  assign info = lenDecode(lenCode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseCol  <= '0;
      beatIdx  <= '0;
      lowMask  <= '0;
      ilvMode  <= 1'b0;
      fullMode <= 1'b0;
    end else if (strobes.load) begin
      baseCol  <= startCol;
      beatIdx  <= '0;
      lowMask  <= COL_W'(info.beats - 4'd1);
      ilvMode  <= interleave;
      fullMode <= info.full;
    end else if (strobes.step) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  assign seqLow = (baseCol + beatIdx) & lowMask;
  assign ilvLow = (baseCol ^ beatIdx) & lowMask;

  always_comb begin
    if (fullMode)
      colAddr = baseCol + beatIdx;
    else if (ilvMode)
      colAddr = (baseCol & ~lowMask) | ilvLow;
    else
      colAddr = (baseCol & ~lowMask) | seqLow;
  end

  // R3/R4: upper bits stay fixed across a fixed-length burst
  a_r3_hold_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && !fullMode)
      |=> ((colAddr & ~lowMask) == $past(colAddr & ~lowMask)));

  // R6: full page advances by one column per beat, wrapping
  a_r6_full_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && fullMode)
      |=> (colAddr == COL_W'($past(colAddr) + 1'b1)));

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             terminate,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             lastBeat
);

  strobe_t strobes;

  burst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .lenCode  (lenCode),
    .terminate(terminate),
    .strobes  (strobes),
    .busy     (colValid),
    .lastBeat (lastBeat)
  );

  burst_datapath #(.COL_W(COL_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .startCol  (startCol),
    .lenCode   (lenCode),
    .interleave(interleave),
    .colAddr   (colAddr)
  );

  // R7: last-beat flag only with a valid beat
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> colValid);

endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = '0;
  logic             interleave = 1'b0;
  logic             terminate = 1'b0;
  logic [COL_W-1:0] colAddr;
  logic             colValid;
  logic             lastBeat;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .terminate(terminate),
    .colAddr(colAddr), .colValid(colValid), .lastBeat(lastBeat)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int beatsOf(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int expAddr(input int col, input int n, input int k, input int ilv);
    int mask = n - 1;
    if (ilv != 0) return (col & ~mask & (PAGE - 1)) | ((col ^ k) & mask);
    return (col & ~mask & (PAGE - 1)) | ((col + k) & mask);
  endfunction

  // Runs one fixed burst; a stray start is driven on beat 0 (R9)
  task automatic fixedBurst(input int code, input int ilv, input int col);
    int n = beatsOf(code);
    @(negedge clk);
    start = 1'b1; startCol = COL_W'(col); lenCode = 3'(code); interleave = ilv[0];
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      check("R2/R5 valid", int'(colValid), 1);
      if (n == 1) check("R2/R5 addr", int'(colAddr), col);
      else if (ilv != 0) check("R4 addr", int'(colAddr), expAddr(col, n, k, ilv));
      else check("R3 addr", int'(colAddr), expAddr(col, n, k, ilv));
      check("R7 last", int'(lastBeat), (k == n - 1) ? 1 : 0);
      if (k == 0) begin
        start = 1'b1;
        startCol = COL_W'(col + 77);
        lenCode = 3'b111;
        interleave = ~ilv[0];
      end
      @(negedge clk);
      start = 1'b0;
    end
    check("R5/R7/R9 ends", int'(colValid), 0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", int'(colValid), 0);
    check("R1 last", int'(lastBeat), 0);

    // R3 R4 R5 R9: sweep all codes except full page, both orders, all columns
    for (int code = 0; code < 7; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int col = 0; col < PAGE; col++)
          fixedBurst(code, ilv, col);

    // R8: terminate mid burst after beat 2
    @(negedge clk);
    start = 1'b1; startCol = 8'd5; lenCode = 3'b011; interleave = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R8 addr", int'(colAddr), expAddr(5, 8, k, 0));
      if (k == 2) terminate = 1'b1;
      @(negedge clk);
    end
    terminate = 1'b0;
    check("R8 stopped", int'(colValid), 0);
    @(negedge clk);
    check("R8 stays idle", int'(colValid), 0);

    // R8: terminate while idle and together with an accepted start
    terminate = 1'b1;
    @(negedge clk);
    check("R8 idle term", int'(colValid), 0);
    start = 1'b1; startCol = 8'd12; lenCode = 3'b010; interleave = 1'b1;
    @(negedge clk);
    start = 1'b0; terminate = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R8 full length addr", int'(colAddr), expAddr(12, 4, k, 1));
      check("R8 full length last", int'(lastBeat), (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    check("R8 end", int'(colValid), 0);

    // R6: full page, interleave bit set but ignored, wraps past 255
    start = 1'b1; startCol = 8'd250; lenCode = 3'b111; interleave = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 300; k++) begin
      check("R6 valid", int'(colValid), 1);
      check("R6 addr", int'(colAddr), (250 + k) % PAGE);
      check("R7 no last in full", int'(lastBeat), 0);
      if (k == 10) start = 1'b1;
      if (k == 299) terminate = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    terminate = 1'b0;
    check("R6/R8 full stop", int'(colValid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule